// File: doc/BRIEF.md
# Fuse Array Word Read Sequencer

This block reads one 32-bit word from a one-time-programmable fuse macro. The macro has no built-in read cycle. Each access has to be wrapped in a power-up, clock and power-down sequence on its control pins. A client presents a word index together with a one-cycle start strobe. The sequencer takes the macro out of deep standby and enables its repair logic, then its chip enable. It puts the index on the address pins and gives the macro a single clock pulse. The high and low phases of that pulse each last a set number of system cycles.

Once the low phase ends, the sequencer captures the macro's data output. It then drops the control pins in the reverse order. Only after the macro is back in standby does it present the captured word with a one-cycle done pulse. An index beyond the array never touches the macro and gives a one-cycle error pulse instead. Programming, test and redundancy pins are driven inactive at all times.

Top module: `otp_read_seq`

## Requirements
- R1: A start strobe in idle with an index of WORDS (4096) or above produces `error_o` high for exactly the next cycle. `busy_o` stays low and no macro pin changes.
- R2: A start strobe in idle with an index below WORDS raises `busy_o` and `fuse_standby_n_o` (1 = awake) in the next cycle. Both rise together.
- R3: `fuse_repair_o` rises one cycle after the wake-up and `fuse_en_o` rises one cycle after that. One cycle later `fuse_addr_o` carries the low 12 index bits.
- R4: `fuse_clk_o` rises one cycle after the address is driven. It stays high for HOLD_HI cycles and then stays low for HOLD_LO cycles. Both parameters are at least 1.
- R5: The macro's data output is captured at the end of the low hold, and that word is later presented on `data_o`.
- R6: At the end of the low hold, `fuse_en_o` falls and `fuse_addr_o` returns to 0. `fuse_repair_o` falls one cycle later, and `fuse_standby_n_o` falls one cycle after that.
- R7: `done_o` is high for exactly one cycle, one cycle after `fuse_standby_n_o` falls, and `data_o` is valid in that cycle. `busy_o` stays high up to and including that cycle and is low in the next one. `data_o` then holds until the next done.
- R8: A start strobe while `busy_o` is high is ignored. The running read keeps its timing and its index, and it gives exactly one done.
- R9: `fuse_prog_o`, `fuse_we_o` and `fuse_test_o` stay 0 at all times.
- R10: While `fuse_en_o` is high, `fuse_repair_o` and `fuse_standby_n_o` are both high. While `fuse_clk_o` is high, `fuse_en_o` is high.
- R11: After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle read request |
| index_i | input | IDX_W (16) | Word index to read |
| busy_o | output | 1 | Read in progress, through the done cycle |
| done_o | output | 1 | One-cycle completion pulse |
| error_o | output | 1 | One-cycle pulse for an out-of-range index |
| data_o | output | 32 | Word read, valid with done_o |
| fuse_standby_n_o | output | 1 | Macro deep-standby control, low = standby |
| fuse_repair_o | output | 1 | Macro repair-function enable |
| fuse_en_o | output | 1 | Macro chip enable |
| fuse_addr_o | output | ADDR_W (12) | Macro word address |
| fuse_clk_o | output | 1 | Macro clock |
| fuse_rdata_i | input | 32 | Macro data output |
| fuse_prog_o | output | 1 | Macro program-mode enable, held 0 |
| fuse_we_o | output | 1 | Macro write enable, held 0 |
| fuse_test_o | output | 1 | Macro test-mode enable, held 0 |

## Verification
The bench builds the block with HOLD_HI = 3 and HOLD_LO = 2. Because the two holds differ, a swap of the high and low counts, or a hold that is off by one, shifts the clock fall or the enable drop to a cycle the bench does not expect. These short holds keep each read to thirteen cycles. That leaves room for both array ends (0 and 0xFFF), the first index out of range and the largest one, and a stray start injected in the middle of the clock-high phase. The macro model only returns valid data when its clock rises with all three enables set, so a pin sequence in the wrong order corrupts the word that comes back.

// File: rtl/otp_seq_pkg.sv
package otp_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WAKE,
    ST_REPAIR,
    ST_ENABLE,
    ST_ADDR,
    ST_CLK_HI,
    ST_CLK_LO,
    ST_DROP_EN,
    ST_DROP_REP,
    ST_SLEEP,
    ST_DONE
  } seq_state_e;

endpackage

// File: rtl/otp_hold_timer.sv
module otp_hold_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expired_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/otp_seq_fsm.sv
module otp_seq_fsm
  import otp_seq_pkg::*;
#(
  parameter int HOLD_HI = 4,
  parameter int HOLD_LO = 4,
  parameter int CNT_W   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             in_range_i,
  input  logic             expired_i,
  output seq_state_e       state_q_o,
  output seq_state_e       state_d_o,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output logic             accept_o,
  output logic             reject_o
);

  localparam logic [CNT_W-1:0] HI_LOAD = CNT_W'(HOLD_HI - 1);
  localparam logic [CNT_W-1:0] LO_LOAD = CNT_W'(HOLD_LO - 1);

  seq_state_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    load_o     = 1'b0;
    load_val_o = '0;
    accept_o   = 1'b0;
    reject_o   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          if (in_range_i) begin
            state_d  = ST_WAKE;
            accept_o = 1'b1;
          end else begin
            reject_o = 1'b1;
          end
        end
      end
      ST_WAKE:   state_d = ST_REPAIR;
      ST_REPAIR: state_d = ST_ENABLE;
      ST_ENABLE: state_d = ST_ADDR;
      ST_ADDR: begin
        state_d    = ST_CLK_HI;
        load_o     = 1'b1;
        load_val_o = HI_LOAD;
      end
      ST_CLK_HI: begin
        if (expired_i) begin
          state_d    = ST_CLK_LO;
          load_o     = 1'b1;
          load_val_o = LO_LOAD;
        end
      end
      ST_CLK_LO: begin
        if (expired_i) state_d = ST_DROP_EN;
      end
      ST_DROP_EN:  state_d = ST_DROP_REP;
      ST_DROP_REP: state_d = ST_SLEEP;
      ST_SLEEP:    state_d = ST_DONE;
      ST_DONE:     state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  assign state_q_o = state_q;
  assign state_d_o = state_d;

endmodule

// File: rtl/otp_seq_pins.sv
module otp_seq_pins
  import otp_seq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  seq_state_e        state_q_i,
  input  seq_state_e        state_d_i,
  input  logic              accept_i,
  input  logic              reject_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] fuse_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              error_o,
  output logic [DATA_W-1:0] data_o,
  output logic              fuse_standby_n_o,
  output logic              fuse_repair_o,
  output logic              fuse_en_o,
  output logic [ADDR_W-1:0] fuse_addr_o,
  output logic              fuse_clk_o
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] cap_q;
  logic              capture;

  assign capture = (state_q_i == ST_CLK_LO) && (state_d_i == ST_DROP_EN);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      cap_q  <= '0;
    end else begin
      if (accept_i) addr_q <= addr_i;
      if (capture)  cap_q  <= fuse_rdata_i;
    end
  end

  // Every pin level is registered from the next state, so pins change
  // exactly on the edge where the sequence enters a step.
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o           <= 1'b0;
      done_o           <= 1'b0;
      error_o          <= 1'b0;
      data_o           <= '0;
      fuse_standby_n_o <= 1'b0;
      fuse_repair_o    <= 1'b0;
      fuse_en_o        <= 1'b0;
      fuse_addr_o      <= '0;
      fuse_clk_o       <= 1'b0;
    end else begin
      busy_o           <= (state_d_i != ST_IDLE);
      done_o           <= (state_d_i == ST_DONE);
      error_o          <= reject_i;
      fuse_standby_n_o <= state_d_i inside {[ST_WAKE:ST_DROP_REP]};
      fuse_repair_o    <= state_d_i inside {[ST_REPAIR:ST_DROP_EN]};
      fuse_en_o        <= state_d_i inside {[ST_ENABLE:ST_CLK_LO]};
      fuse_addr_o      <= (state_d_i inside {[ST_ADDR:ST_CLK_LO]}) ? addr_q : '0;
      fuse_clk_o       <= (state_d_i == ST_CLK_HI);
      if (state_d_i == ST_DONE) data_o <= cap_q;
    end
  end

endmodule

// File: rtl/otp_read_seq.sv
module otp_read_seq #(
  parameter int WORDS   = 4096,
  parameter int IDX_W   = 16,
  parameter int DATA_W  = 32,
  parameter int HOLD_HI = 4,
  parameter int HOLD_LO = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start_i,
  input  logic [IDX_W-1:0]        index_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic                    error_o,
  output logic [DATA_W-1:0]       data_o,
  output logic                    fuse_standby_n_o,
  output logic                    fuse_repair_o,
  output logic                    fuse_en_o,
  output logic [$clog2(WORDS)-1:0] fuse_addr_o,
  output logic                    fuse_clk_o,
  input  logic [DATA_W-1:0]       fuse_rdata_i,
  output logic                    fuse_prog_o,
  output logic                    fuse_we_o,
  output logic                    fuse_test_o
);

  import otp_seq_pkg::*;

  localparam int ADDR_W   = $clog2(WORDS);
  localparam int MAX_HOLD = (HOLD_HI > HOLD_LO) ? HOLD_HI : HOLD_LO;
  localparam int CNT_W    = (MAX_HOLD > 1) ? $clog2(MAX_HOLD) : 1;

  seq_state_e       state_q, state_d;
  logic             load, expired, accept, reject, in_range;
  logic [CNT_W-1:0] load_val;

  assign in_range = ({1'b0, index_i} < (IDX_W + 1)'(WORDS));

  otp_seq_fsm #(
    .HOLD_HI (HOLD_HI),
    .HOLD_LO (HOLD_LO),
    .CNT_W   (CNT_W)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .in_range_i (in_range),
    .expired_i  (expired),
    .state_q_o  (state_q),
    .state_d_o  (state_d),
    .load_o     (load),
    .load_val_o (load_val),
    .accept_o   (accept),
    .reject_o   (reject)
  );

  otp_hold_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk        (clk),
    .rst        (rst),
    .load_i     (load),
    .load_val_i (load_val),
    .expired_o  (expired)
  );

  otp_seq_pins #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_pins (
    .clk              (clk),
    .rst              (rst),
    .state_q_i        (state_q),
    .state_d_i        (state_d),
    .accept_i         (accept),
    .reject_i         (reject),
    .addr_i           (index_i[ADDR_W-1:0]),
    .fuse_rdata_i     (fuse_rdata_i),
    .busy_o           (busy_o),
    .done_o           (done_o),
    .error_o          (error_o),
    .data_o           (data_o),
    .fuse_standby_n_o (fuse_standby_n_o),
    .fuse_repair_o    (fuse_repair_o),
    .fuse_en_o        (fuse_en_o),
    .fuse_addr_o      (fuse_addr_o),
    .fuse_clk_o       (fuse_clk_o)
  );

  // Programming and test controls are never exercised by a read.
  assign fuse_prog_o = 1'b0;
  assign fuse_we_o   = 1'b0;
  assign fuse_test_o = 1'b0;

endmodule

// File: rtl/otp_read_seq_chk.sv
module otp_read_seq_chk (
  input logic clk,
  input logic rst,
  input logic start_i,
  input logic busy_o,
  input logic done_o,
  input logic error_o,
  input logic fuse_standby_n_o,
  input logic fuse_repair_o,
  input logic fuse_en_o,
  input logic fuse_clk_o
);

  // R1
  error_never_busy_chk: assert property (@(posedge clk) disable iff (rst)
    error_o |-> !busy_o);

  // R1
  error_single_chk: assert property (@(posedge clk) disable iff (rst)
    error_o |=> !error_o);

  // R2
  wake_with_busy_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $rose(fuse_standby_n_o));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> (!done_o && !busy_o));

  // R7
  done_after_sleep_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (busy_o && !fuse_standby_n_o && !fuse_en_o && !fuse_repair_o));

  // R8
  no_abort_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !done_o && start_i) |=> busy_o);

  // R10
  enable_order_chk: assert property (@(posedge clk) disable iff (rst)
    fuse_en_o |-> (fuse_repair_o && fuse_standby_n_o));

  // R10
  repair_order_chk: assert property (@(posedge clk) disable iff (rst)
    fuse_repair_o |-> fuse_standby_n_o);

  // R10
  clk_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
    fuse_clk_o |-> fuse_en_o);

endmodule

bind otp_read_seq otp_read_seq_chk u_chk (
  .clk              (clk),
  .rst              (rst),
  .start_i          (start_i),
  .busy_o           (busy_o),
  .done_o           (done_o),
  .error_o          (error_o),
  .fuse_standby_n_o (fuse_standby_n_o),
  .fuse_repair_o    (fuse_repair_o),
  .fuse_en_o        (fuse_en_o),
  .fuse_clk_o       (fuse_clk_o)
);

// File: tb/tb_otp_read_seq.sv
module tb_otp_read_seq;

  localparam int HI = 3;
  localparam int LO = 2;
  localparam int NV = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [15:0] index_i = '0;
  logic        busy_o, done_o, error_o;
  logic [31:0] data_o;
  logic        fuse_standby_n_o, fuse_repair_o, fuse_en_o, fuse_clk_o;
  logic [11:0] fuse_addr_o;
  logic [31:0] fuse_rdata_i;
  logic        fuse_prog_o, fuse_we_o, fuse_test_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2 clk = ~clk;

  otp_read_seq #(
    .HOLD_HI (HI),
    .HOLD_LO (LO)
  ) dut (
    .clk              (clk),
    .rst              (rst),
    .start_i          (start_i),
    .index_i          (index_i),
    .busy_o           (busy_o),
    .done_o           (done_o),
    .error_o          (error_o),
    .data_o           (data_o),
    .fuse_standby_n_o (fuse_standby_n_o),
    .fuse_repair_o    (fuse_repair_o),
    .fuse_en_o        (fuse_en_o),
    .fuse_addr_o      (fuse_addr_o),
    .fuse_clk_o       (fuse_clk_o),
    .fuse_rdata_i     (fuse_rdata_i),
    .fuse_prog_o      (fuse_prog_o),
    .fuse_we_o        (fuse_we_o),
    .fuse_test_o      (fuse_test_o)
  );

  function automatic logic [31:0] word_of(input logic [11:0] a);
    return {~a, 4'h5, a, 4'hC};
  endfunction

  // Macro model: latches a word on a rising macro clock, valid only when
  // the macro is awake, repaired and enabled.
  logic clk_prev;
  always_ff @(posedge clk) begin
    if (rst) begin
      clk_prev     <= 1'b0;
      fuse_rdata_i <= 32'h0;
    end else begin
      clk_prev <= fuse_clk_o;
      if (fuse_clk_o && !clk_prev)
        fuse_rdata_i <= (fuse_standby_n_o && fuse_repair_o && fuse_en_o)
                        ? word_of(fuse_addr_o) : 32'hBAD0_BAD0;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung, act=%0d exp<=100000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // Vector table: index and whether it is out of range.
  localparam logic [16:0] VEC [NV] = '{
    {16'h0000, 1'b0}, {16'h0FFF, 1'b0}, {16'h1000, 1'b1}, {16'h0123, 1'b0},
    {16'hFFFF, 1'b1}, {16'h0ABC, 1'b0}, {16'h0800, 1'b0}, {16'h1001, 1'b1}
  };

  // Launch a read and record, relative to the start edge, the cycle of each
  // pin event. inject puts a stray start with another index in the clock-high phase.
  task automatic run_read(input logic [15:0] idx, input bit inject);
    int n_wake = 0, n_rep = 0, n_en = 0, n_clkr = 0, n_clkf = 0;
    int n_enf = 0, n_repf = 0, n_wakef = 0, n_done = 0, dones = 0;
    bit busy_ok = 1, idle_ok = 1, addr_ok = 1;
    logic pw = 0, pr = 0, pe = 0, pc = 0;
    int ch, cl, ef, rf, wf, dn;
    ch = 5; cl = ch + HI; ef = cl + LO; rf = ef + 1; wf = rf + 1; dn = wf + 1;
    @(negedge clk);
    start_i = 1'b1;
    index_i = idx;
    for (int n = 1; n <= dn + 3; n++) begin
      @(negedge clk);
      start_i = 1'b0;
      if (inject && n == 6) begin
        start_i = 1'b1;
        index_i = idx ^ 16'h0FF;
      end
      if (fuse_standby_n_o && !pw) n_wake = n;
      if (!fuse_standby_n_o && pw) n_wakef = n;
      if (fuse_repair_o && !pr) n_rep = n;
      if (!fuse_repair_o && pr) n_repf = n;
      if (fuse_en_o && !pe) n_en = n;
      if (!fuse_en_o && pe) n_enf = n;
      if (fuse_clk_o && !pc) n_clkr = n;
      if (!fuse_clk_o && pc) n_clkf = n;
      pw = fuse_standby_n_o; pr = fuse_repair_o; pe = fuse_en_o; pc = fuse_clk_o;
      if (done_o) begin dones++; if (n_done == 0) n_done = n; end
      if (n <= dn && !busy_o) busy_ok = 0;
      if (n > dn && busy_o) busy_ok = 0;
      if (fuse_prog_o || fuse_we_o || fuse_test_o || error_o) idle_ok = 0;
      if (n >= 4 && n < ef && fuse_addr_o != idx[11:0]) addr_ok = 0;
      if (n >= ef && fuse_addr_o != 12'h0) addr_ok = 0;
      if (n == dn)
        check(data_o == word_of(idx[11:0]), "R5 data word at done", data_o,
              word_of(idx[11:0]));
    end
    index_i = '0;
    check(n_wake == 1, "R2 wake cycle", n_wake, 1);
    check(n_rep == 2 && n_en == 3, "R3 repair/enable cycles", {n_rep[15:0], n_en[15:0]}, {16'd2, 16'd3});
    check(addr_ok, "R3/R6 address window", fuse_addr_o, idx[11:0]);
    check(n_clkr == ch && n_clkf == cl, "R4 clock high/low hold",
          {n_clkr[15:0], n_clkf[15:0]}, {ch[15:0], cl[15:0]});
    check(n_enf == ef && n_repf == rf && n_wakef == wf, "R6 shutdown order",
          {n_enf[7:0], n_repf[7:0], n_wakef[7:0]}, {ef[7:0], rf[7:0], wf[7:0]});
    check(n_done == dn && dones == 1, "R7 done cycle and width",
          {n_done[15:0], dones[15:0]}, {dn[15:0], 16'd1});
    check(busy_ok, "R7 busy window", busy_o, 0);
    check(idle_ok, "R9 inactive pins", {fuse_prog_o, fuse_we_o, fuse_test_o}, 0);
    if (inject) check(dones == 1 && n_done == dn, "R8 stray start ignored", dones, 1);
  endtask

  task automatic run_bad(input logic [15:0] idx);
    logic [31:0] held;
    bit quiet = 1;
    held = data_o;
    @(negedge clk);
    start_i = 1'b1;
    index_i = idx;
    @(negedge clk);
    start_i = 1'b0;
    check(error_o && !busy_o && !fuse_standby_n_o, "R1 error pulse", {error_o, busy_o}, 2'b10);
    for (int n = 2; n <= 16; n++) begin
      @(negedge clk);
      if (error_o || busy_o || done_o || fuse_standby_n_o || fuse_clk_o) quiet = 0;
    end
    check(quiet && data_o == held, "R1 no read started", data_o, held);
    index_i = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check(!busy_o && !done_o && !error_o && data_o == 0 && !fuse_standby_n_o &&
          !fuse_repair_o && !fuse_en_o && !fuse_clk_o && fuse_addr_o == 0,
          "R11 reset outputs", {busy_o, done_o, error_o, fuse_standby_n_o}, 0);

    for (int v = 0; v < NV; v++) begin
      if (VEC[v][0]) run_bad(VEC[v][16:1]);
      else           run_read(VEC[v][16:1], 1'b0);
    end

    // R8 stray start in the middle of a read
    run_read(16'h0055, 1'b1);

    // R7 data holds after done
    repeat (10) @(negedge clk);
    check(data_o == word_of(12'h055), "R7 data holds", data_o, word_of(12'h055));

    // R10 ordering with minimum-length read right after a reject
    run_bad(16'h2000);
    run_read(16'h0FFE, 1'b0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule